// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor core that retires one instruction on every clock edge. In one cycle it fetches a 32-bit instruction from its internal instruction store and decodes the opcode into a fixed set of control points. It then reads two source registers, runs the ALU, optionally reads or writes its internal data store, and commits the result. The program counter advances on the same edge. The supported operations are register-register add, subtract, bitwise and, bitwise or and signed set-less-than, plus word load, word store and branch-if-equal.

Both stores read combinationally and write on the rising clock edge. Their contents are placed from outside the core by hierarchical access before a program runs. The core exposes its program counter and a per-cycle trace of its register write-back and data-store write. An integrator can observe what each instruction commits through these ports.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low on a rising edge, the program counter becomes 0 (synchronous, active-low reset). No register or data-store write commits while reset is low, so `rf_we_o` and `dm_we_o` read 0. Data-store contents survive a reset.
- R2: Outside reset, an instruction that is not a taken branch sets the next program counter to the current one plus 4.
- R3: Branch-if-equal has opcode 4 with rs in bits 25-21, rt in 20-16 and a 16-bit signed offset in 15-0. When R[rs] equals R[rt], the next program counter is PC+4 plus the sign-extended offset shifted left by two; this holds for negative offsets too. Otherwise the next program counter is PC+4. The branch never writes a register or the data store.
- R4: Opcode 0 is register-register: rd in bits 15-11 receives R[rs] op R[rt]. The funct field in bits 5-0 selects the op: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R5: Load word, opcode 35, writes rt with the data word at address R[rs] plus the sign-extended 16-bit offset.
- R6: Store word, opcode 43, writes R[rt] to the data word at address R[rs] plus the sign-extended offset, and writes no register. Data-store and instruction-store words are selected by address bits [N+1:2]; the two low address bits are ignored.
- R7: Register 0 always reads as zero. A write aimed at it has no effect.
- R8: Any opcode other than 0, 35, 43 and 4 writes nothing and advances the program counter by 4.
- R9: A word stored by one instruction is returned by a load of the same word in the very next instruction.
- Trace encoding: `rf_we_o`/`rf_waddr_o`/`rf_wdata_o` show the register write that commits at the coming edge. `dm_we_o`/`dm_addr_o`/`dm_wdata_o` show the data-store write and its full byte address. Both are combinational from the current instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write-back commits at the coming edge |
| rf_waddr_o | output | 5 | Destination register number of the write-back |
| rf_wdata_o | output | 32 | Write-back data (ALU result or loaded word) |
| dm_we_o | output | 1 | Data-store write commits at the coming edge |
| dm_addr_o | output | 32 | Data access byte address (R[rs] + offset) |
| dm_wdata_o | output | 32 | Data written to the data store |

## Verification
The two functions that share an edge are the write commit (a register or a data word) and the program counter advance. On the next cycle the following instruction must already see the new value through the combinational read paths. Two cases in the program provoke this. Loads feed ALU instructions back to back. A store is followed at once by a load of the same word through a different base and offset, with nonzero byte-offset bits. A branch also compares a register that was just loaded. The program is judged by the write-back value and the program counter that the following cycle presents: a stale read shows up as a wrong trace value, and a wrong branch decision shows up as a wrong program counter.

// File: rtl/sc_pkg.sv
// Package sc_pkg: shared widths, opcode and funct codes, ALU operation
// encoding and the decoded control bundle of the single-cycle core.
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OP_RTYPE = 6'd0;
    localparam logic [5:0] OP_LW    = 6'd35;
    localparam logic [5:0] OP_SW    = 6'd43;
    localparam logic [5:0] OP_BEQ   = 6'd4;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'd0,
        ALU_OR  = 4'd1,
        ALU_ADD = 4'd2,
        ALU_SUB = 4'd6,
        ALU_SLT = 4'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        AC_MEM  = 2'b00,
        AC_CMP  = 2'b01,
        AC_FUNC = 2'b10
    } alu_class_e;

    typedef struct packed {
        logic       dst_is_rd;
        logic       b_is_imm;
        logic       wb_from_mem;
        logic       reg_write;
        logic       mem_read;
        logic       mem_write;
        logic       branch;
        alu_class_e alu_class;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
// sc_decode: main control and ALU control.
// The opcode selects one of four instruction classes, each with a fixed
// set of control points. For the register class the funct field then
// picks the ALU operation. Assumes nothing about the other fields.
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_op_e    alu_op
);
    // Main decode: one fixed control word per instruction class.
    always_comb begin
        ctrl = '{dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
                 reg_write: 1'b0, mem_read: 1'b0, mem_write: 1'b0,
                 branch: 1'b0, alu_class: AC_MEM};
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_class = AC_FUNC;
            end
            OP_LW: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
                ctrl.mem_read    = 1'b1;
            end
            OP_SW: begin
                ctrl.b_is_imm  = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch    = 1'b1;
                ctrl.alu_class = AC_CMP;
            end
            default: ;
        endcase
    end

    // ALU control: the class forces add or subtract, else funct decides.
    always_comb begin
        alu_op = ALU_ADD;
        case (ctrl.alu_class)
            AC_CMP:  alu_op = ALU_SUB;
            AC_FUNC: begin
                case (funct)
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: alu_op = ALU_ADD;
                endcase
            end
            default: alu_op = ALU_ADD;
        endcase
    end

    // Decode checks: loads write rt from memory, stores write no register,
    // unknown opcodes stay quiet.
    always_comb begin
        if (opcode == OP_LW)
            p_lw_decode_r5: assert (ctrl.reg_write && ctrl.wb_from_mem && !ctrl.dst_is_rd && alu_op == ALU_ADD);
        if (opcode == OP_SW)
            p_sw_decode_r6: assert (ctrl.mem_write && !ctrl.reg_write && alu_op == ALU_ADD);
        if (opcode != OP_RTYPE && opcode != OP_LW && opcode != OP_SW && opcode != OP_BEQ)
            p_unknown_quiet_r8: assert (!ctrl.reg_write && !ctrl.mem_write && !ctrl.branch);
    end
endmodule

// File: rtl/sc_regfile.sv
// sc_regfile: register file with two combinational read ports and one
// write port that commits on the rising edge. Entry 0 is hard-wired to
// zero and its writes are dropped. Assumes the caller gates we in reset.
module sc_regfile #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] regs_q [NREG];

    // Write port: commit on the edge, never into entry 0.
    always_ff @(posedge clk) begin
        if (we && waddr != '0)
            regs_q[waddr] <= wdata;
    end

    // Read ports: combinational, entry 0 forced to zero.
    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
    end
endmodule

// File: rtl/sc_alu.sv
// sc_alu: combinational ALU for and, or, add, subtract and signed
// set-less-than, with a zero flag on the result. Wraps on overflow.
module sc_alu
    import sc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             zero
);
    // Operation select.
    always_comb begin
        case (op)
            ALU_AND: result = a & b;
            ALU_OR:  result = a | b;
            ALU_SUB: result = a - b;
            ALU_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: result = a + b;
        endcase
        zero = (result == '0);
    end

    // Set-less-than yields only 0 or 1.
    always_comb begin
        if (op == ALU_SLT)
            p_slt_bool_r4: assert (result[WIDTH-1:1] == '0);
    end
endmodule

// File: rtl/sc_core.sv
// sc_core: single-cycle processor top. It holds the program counter, the
// instruction and data stores (combinational read, clocked write), the
// sign extender, the branch adder and the datapath selects. Stores are
// word-addressed through address bits [N+1:2]. Contents are placed by
// hierarchical access; the instruction store starts all zero.
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   pc_o,
    output logic              rf_we_o,
    output logic [REG_AW-1:0] rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              dm_we_o,
    output logic [XLEN-1:0]   dm_addr_o,
    output logic [XLEN-1:0]   dm_wdata_o
);
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target;
    logic [XLEN-1:0]   instr, imm_ext, rd_a, rd_b, alu_b, alu_res, ld_data, wb_data;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd, wb_reg;
    logic              alu_zero, take_br, rf_we, dm_we;
    ctrl_t             ctrl;
    alu_op_e           alu_op;
    logic              unused_bits;

    // Instruction store starts cleared; the bench overwrites it afterwards.
    initial begin
        for (int k = 0; k < IMEM_WORDS; k++)
            imem_q[k] = '0;
    end

    // Fetch and field split.
    always_comb begin
        instr   = imem_q[pc_q[IAW+1:2]];
        f_rs    = instr[25:21];
        f_rt    = instr[20:16];
        f_rd    = instr[15:11];
        imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
    end

    sc_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .alu_op (alu_op)
    );

    sc_regfile #(.NREG(1 << REG_AW), .WIDTH(XLEN)) u_regfile (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (wb_reg),
        .wdata   (wb_data),
        .raddr_a (f_rs),
        .raddr_b (f_rt),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    // Second ALU operand select.
    always_comb alu_b = ctrl.b_is_imm ? imm_ext : rd_b;

    sc_alu #(.WIDTH(XLEN)) u_alu (
        .op     (alu_op),
        .a      (rd_a),
        .b      (alu_b),
        .result (alu_res),
        .zero   (alu_zero)
    );

    // Data read, write-back select and commit enables.
    always_comb begin
        ld_data = dmem_q[alu_res[DAW+1:2]];
        wb_data = ctrl.wb_from_mem ? ld_data : alu_res;
        wb_reg  = ctrl.dst_is_rd ? f_rd : f_rt;
        rf_we   = ctrl.reg_write & rst_n;
        dm_we   = ctrl.mem_write & rst_n;
    end

    // Next program counter: sequential or branch target.
    always_comb begin
        pc_plus4  = pc_q + XLEN'(4);
        br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        take_br   = ctrl.branch & alu_zero;
        pc_next   = take_br ? br_target : pc_plus4;
    end

    // Program counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else
            pc_q <= pc_next;
    end

    // Data store write port.
    always_ff @(posedge clk) begin
        if (dm_we)
            dmem_q[alu_res[DAW+1:2]] <= rd_b;
    end

    // Trace outputs.
    always_comb begin
        pc_o       = pc_q;
        rf_we_o    = rf_we;
        rf_waddr_o = wb_reg;
        rf_wdata_o = wb_data;
        dm_we_o    = dm_we;
        dm_addr_o  = alu_res;
        dm_wdata_o = rd_b;
    end

    // Fields and address bits the datapath does not consume.
    assign unused_bits = ^{instr[10:6], pc_q[1:0], pc_q[XLEN-1:IAW+2],
                           alu_res[1:0], alu_res[XLEN-1:DAW+2], ctrl.mem_read};

    // Reset drives the program counter to zero on the next edge.
    p_pc_reset_r1: assert property (@(posedge clk) !rst_n |=> (pc_q == '0));

    // A non-branching cycle advances by one word.
    p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take_br |=> (pc_q == $past(pc_q) + XLEN'(4)));

    // A taken branch lands on PC+4 plus the scaled offset.
    p_branch_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_br |=> (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_ext[XLEN-3:0]), 2'b00}));
endmodule

// File: tb/sc_core_bench.sv
// sc_core_bench: preloads a program and data words, walks a table of
// expected per-cycle traces, then runs directed reset checks.
module sc_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 21;

    typedef struct packed {
        logic [31:0] pc;
        logic        rf_we;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic        dm_we;
        logic [31:0] daddr;
        logic [31:0] ddata;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'd0,  1'b1, 5'd1,  32'd5,          1'b0, 32'd0,  32'd0,  4'd5},
        '{32'd4,  1'b1, 5'd2,  32'd3,          1'b0, 32'd0,  32'd0,  4'd5},
        '{32'd8,  1'b1, 5'd3,  32'hFFFF_FFF0,  1'b0, 32'd0,  32'd0,  4'd5},
        '{32'd12, 1'b1, 5'd4,  32'd8,          1'b0, 32'd0,  32'd0,  4'd4},
        '{32'd16, 1'b1, 5'd5,  32'd2,          1'b0, 32'd0,  32'd0,  4'd4},
        '{32'd20, 1'b1, 5'd6,  32'd1,          1'b0, 32'd0,  32'd0,  4'd4},
        '{32'd24, 1'b1, 5'd7,  32'd7,          1'b0, 32'd0,  32'd0,  4'd4},
        '{32'd28, 1'b1, 5'd8,  32'd1,          1'b0, 32'd0,  32'd0,  4'd4},
        '{32'd32, 1'b1, 5'd9,  32'd0,          1'b0, 32'd0,  32'd0,  4'd4},
        '{32'd36, 1'b1, 5'd0,  32'd8,          1'b0, 32'd0,  32'd0,  4'd7},
        '{32'd40, 1'b1, 5'd10, 32'd5,          1'b0, 32'd0,  32'd0,  4'd7},
        '{32'd44, 1'b0, 5'd0,  32'd0,          1'b1, 32'd17, 32'd8,  4'd6},
        '{32'd48, 1'b1, 5'd11, 32'd8,          1'b0, 32'd0,  32'd0,  4'd9},
        '{32'd52, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0,  4'd2},
        '{32'd56, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0,  4'd2},
        '{32'd68, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0,  4'd3},
        '{32'd72, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0,  4'd8},
        '{32'd60, 1'b1, 5'd12, 32'd10,         1'b0, 32'd0,  32'd0,  4'd3},
        '{32'd64, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0,  4'd3},
        '{32'd84, 1'b0, 5'd0,  32'd0,          1'b1, 32'd0,  32'd10, 4'd3},
        '{32'd88, 1'b1, 5'd13, 32'd10,         1'b0, 32'd0,  32'd0,  4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_we_o;
    int          checks = 0;
    int          errors = 0;

    sc_core u_sc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_vec(input int i);
        string r;
        r = req_name(VECS[i].req);
        check(r, $sformatf("step %0d pc", i), pc_o, VECS[i].pc);
        check(r, $sformatf("step %0d rf_we", i), {31'd0, rf_we_o}, {31'd0, VECS[i].rf_we});
        if (VECS[i].rf_we) begin
            check(r, $sformatf("step %0d rf_waddr", i), {27'd0, rf_waddr_o}, {27'd0, VECS[i].waddr});
            check(r, $sformatf("step %0d rf_wdata", i), rf_wdata_o, VECS[i].wdata);
        end
        check(r, $sformatf("step %0d dm_we", i), {31'd0, dm_we_o}, {31'd0, VECS[i].dm_we});
        if (VECS[i].dm_we) begin
            check(r, $sformatf("step %0d dm_addr", i), dm_addr_o, VECS[i].daddr);
            check(r, $sformatf("step %0d dm_wdata", i), dm_wdata_o, VECS[i].ddata);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        errors++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1;
        u_sc_core.dmem_q[0] = 32'd5;
        u_sc_core.dmem_q[1] = 32'd3;
        u_sc_core.dmem_q[2] = 32'hFFFF_FFF0;
        u_sc_core.imem_q[0]  = enc_i(6'd35, 0, 1, 16'd0);
        u_sc_core.imem_q[1]  = enc_i(6'd35, 0, 2, 16'd4);
        u_sc_core.imem_q[2]  = enc_i(6'd35, 0, 3, 16'd8);
        u_sc_core.imem_q[3]  = enc_r(1, 2, 4, 6'h20);
        u_sc_core.imem_q[4]  = enc_r(1, 2, 5, 6'h22);
        u_sc_core.imem_q[5]  = enc_r(1, 2, 6, 6'h24);
        u_sc_core.imem_q[6]  = enc_r(1, 2, 7, 6'h25);
        u_sc_core.imem_q[7]  = enc_r(3, 1, 8, 6'h2A);
        u_sc_core.imem_q[8]  = enc_r(1, 3, 9, 6'h2A);
        u_sc_core.imem_q[9]  = enc_r(1, 2, 0, 6'h20);
        u_sc_core.imem_q[10] = enc_r(0, 1, 10, 6'h20);
        u_sc_core.imem_q[11] = enc_i(6'd43, 1, 4, 16'd12);
        u_sc_core.imem_q[12] = enc_i(6'd35, 0, 11, 16'd16);
        u_sc_core.imem_q[13] = enc_i(6'd4, 1, 2, 16'd5);
        u_sc_core.imem_q[14] = enc_i(6'd4, 4, 11, 16'd2);
        u_sc_core.imem_q[15] = enc_r(1, 1, 12, 6'h20);
        u_sc_core.imem_q[16] = enc_i(6'd4, 0, 0, 16'd4);
        u_sc_core.imem_q[17] = enc_i(6'h3F, 1, 14, 16'd0);
        u_sc_core.imem_q[18] = enc_i(6'd4, 0, 0, 16'hFFFC);
        u_sc_core.imem_q[21] = enc_i(6'd43, 0, 12, 16'd0);
        u_sc_core.imem_q[22] = enc_i(6'd35, 0, 13, 16'd0);

        // R1: state while reset is held.
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1", "pc in reset", pc_o, 32'd0);
        check("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
        check("R1", "dm_we in reset", {31'd0, dm_we_o}, 32'd0);

        // Program walk: one table entry per retired instruction.
        rst_n = 1'b1;
        #1;
        check_vec(0);
        for (int i = 1; i < NVEC; i++) begin
            @(negedge clk);
            check_vec(i);
        end

        // R1: reset in mid-run returns to address 0, suppresses commits.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc_o, 32'd0);
        check("R1", "rf_we during reset", {31'd0, rf_we_o}, 32'd0);
        @(negedge clk);
        check("R1", "pc held in reset", pc_o, 32'd0);
        rst_n = 1'b1;
        #1;
        check("R1", "restart rf_we", {31'd0, rf_we_o}, 32'd1);
        check("R1", "data store kept over reset", rf_wdata_o, 32'd10);
        @(negedge clk);
        check("R2", "pc after restart", pc_o, 32'd4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule